// File: doc/BRIEF.md
# Down-Spread Modulation Profile Generator

This block is the digital heart of a down-spread clock generator. It runs on the incoming reference clock. It produces a signed frequency-offset word that an external fractional divider or synthesizer turns into a modulated clock. The offset traces a triangle: it starts at nominal, falls linearly to the selected depth, and climbs back to nominal. One full triangle always takes 256 reference cycles, so the modulation rate is the reference frequency divided by 256.

A two-bit select picks one of three spread depths. The select carries the state of an external three-level pin, and the undriven state is the default. A new select value is adopted only when a new triangle begins, so a ramp is never cut short. An active-low power-down input halts the profile and drops the output-enable flags of both the modulated clock and the unmodulated reference clock, which tells the pads to go high impedance. The reference-clock enable never depends on the spread setting.

Top module: `sscg_profile`

## Requirements
- R1: A synchronous active-high `rst` sampled at an edge gives, after that edge: `offset` = 0, `ss_oe` = 0, `ref_oe` = 0 and phase 0. The depth is set to the mid setting (peak 50), and the first triangle after reset uses that peak whatever `sel` is.
- R2: While running, the internal phase advances by one each cycle, modulo 256. After the n-th running edge since reset or power-down exit, `offset` shows the profile value for phase n mod 256, so the profile repeats every 256 cycles.
- R3: For phase p and peak P, `offset` = -floor(P*t/128), where t = p for p <= 128 and t = 256 - p otherwise. The offset is a signed 16-bit word in units of 0.01 %.
- R4: The spread is down-only: `offset` is never above 0. It is exactly 0 at phase 0 and exactly -P at phase 128.
- R5: `sel` encoding: 2'b00 gives peak 170 (-1.70 %), 2'b01 gives peak 230 (-2.30 %), and 2'b10 (undriven pin) and 2'b11 both give peak 50 (-0.50 %).
- R6: `sel` is sampled only at the edge where the phase wraps from 255 to 0, and while power-down is asserted. A change at any other time leaves the current triangle unaltered.
- R7: While `pd_n` is low at an edge, after that edge `ss_oe` = 0, `ref_oe` = 0, `offset` = 0 and the phase is held at 0.
- R8: On the first edge with `pd_n` high after power-down, the profile restarts: phase becomes 1, with the depth taken from `sel` as it was during power-down.
- R9: `ref_oe` is the registered `pd_n` (0 in reset) and equals `ss_oe`. No value or change of `sel` affects it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference input clock |
| rst | input | 1 | Synchronous reset, active high |
| pd_n | input | 1 | Power-down, active low |
| sel | input | 2 | Spread-depth select code |
| offset | output | 16 | Signed frequency offset, 0.01 % units, never positive |
| ss_oe | output | 1 | Output enable for the modulated clock (0 = high impedance) |
| ref_oe | output | 1 | Output enable for the unmodulated reference clock (0 = high impedance) |

## Verification
The assertions assume that `rst` is high from time zero and that `sel` and `pd_n` are stable across each clock edge. They also assume that every `sel` code is legal, because code 11 folds onto the mid setting. The stimulus changes inputs only on the falling clock edge, holds `rst` from the start, and moves `sel` both mid-triangle and just before a wrap. This exercises the boundary latching against every code, including the redundant one. Power-down is entered from the middle of a ramp, so the restart-from-zero path is checked from a nonzero phase.

// File: rtl/sscg_pkg.sv
package sscg_pkg;

  typedef enum logic [1:0] {
    DEPTH_LO  = 2'd0,
    DEPTH_HI  = 2'd1,
    DEPTH_MID = 2'd2
  } depth_e;

  // Three-level pin code to depth; the redundant code folds onto mid.
  function automatic depth_e decode_sel(input logic [1:0] code);
    case (code)
      2'b00:   decode_sel = DEPTH_LO;
      2'b01:   decode_sel = DEPTH_HI;
      default: decode_sel = DEPTH_MID;
    endcase
  endfunction

endpackage

// File: rtl/sscg_phase_ctr.sv
module sscg_phase_ctr #(
  parameter int PHASE_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run,
  output logic [PHASE_W-1:0] phase_q,
  output logic [PHASE_W-1:0] phase_nxt,
  output logic               wrap_nxt
);

  localparam logic [PHASE_W-1:0] PH_MAX = '1;

  always_comb begin
    wrap_nxt  = run && (phase_q == PH_MAX);
    phase_nxt = run ? phase_q + 1'b1 : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) phase_q <= '0;
    else     phase_q <= phase_nxt;
  end

  // R2: phase advances by one while running
  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    (run && phase_q != PH_MAX) |=> (phase_q == $past(phase_q) + 1'b1));

  // R2: the period closes back at zero
  p_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (run && phase_q == PH_MAX) |=> (phase_q == '0));

  // R7: phase parked at zero during power-down
  p_park_r7: assert property (@(posedge clk) disable iff (rst)
    !run |=> (phase_q == '0));

endmodule

// File: rtl/sscg_depth_sel.sv
module sscg_depth_sel
  import sscg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [1:0] sel,
  output depth_e     depth_q,
  output depth_e     depth_nxt
);

  always_comb begin
    depth_nxt = load ? decode_sel(sel) : depth_q;
  end

  always_ff @(posedge clk) begin
    if (rst) depth_q <= DEPTH_MID;
    else     depth_q <= depth_nxt;
  end

  // R6: depth frozen outside a period boundary or power-down
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !load |=> (depth_q == $past(depth_q)));

endmodule

// File: rtl/sscg_tri_shaper.sv
module sscg_tri_shaper
  import sscg_pkg::*;
#(
  parameter int PHASE_W  = 8,
  parameter int OFS_W    = 16,
  parameter int PEAK_LO  = 170,
  parameter int PEAK_HI  = 230,
  parameter int PEAK_MID = 50
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [PHASE_W-1:0]      phase_nxt,
  input  depth_e                  depth_nxt,
  output logic signed [OFS_W-1:0] offset_q
);

  localparam int FULL   = 2 ** PHASE_W;
  localparam int TRI_W  = PHASE_W + 1;
  localparam int PROD_W = OFS_W + TRI_W;

  logic [TRI_W-1:0]        tri_w;
  logic [OFS_W-1:0]        peak_w;
  logic [PROD_W-1:0]       prod_w;
  logic [OFS_W-1:0]        mag_w;
  logic signed [OFS_W-1:0] offset_nxt;

  always_comb begin
    if (phase_nxt[PHASE_W-1]) tri_w = TRI_W'(FULL) - {1'b0, phase_nxt};
    else                      tri_w = {1'b0, phase_nxt};
    case (depth_nxt)
      DEPTH_LO: peak_w = OFS_W'(PEAK_LO);
      DEPTH_HI: peak_w = OFS_W'(PEAK_HI);
      default:  peak_w = OFS_W'(PEAK_MID);
    endcase
    prod_w     = PROD_W'(peak_w) * PROD_W'(tri_w);
    mag_w      = OFS_W'(prod_w >> (PHASE_W - 1));
    offset_nxt = -$signed(mag_w);
  end

  always_ff @(posedge clk) begin
    if (rst) offset_q <= '0;
    else     offset_q <= offset_nxt;
  end

  // R4: never above nominal
  p_down_only_r4: assert property (@(posedge clk) disable iff (rst)
    offset_q <= 0);

endmodule

// File: rtl/sscg_profile.sv
module sscg_profile
  import sscg_pkg::*;
#(
  parameter int PHASE_W  = 8,
  parameter int OFS_W    = 16,
  parameter int PEAK_LO  = 170,
  parameter int PEAK_HI  = 230,
  parameter int PEAK_MID = 50
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    pd_n,
  input  logic [1:0]              sel,
  output logic signed [OFS_W-1:0] offset,
  output logic                    ss_oe,
  output logic                    ref_oe
);

  localparam logic [PHASE_W-1:0] PH_HALF = PHASE_W'(2 ** (PHASE_W - 1));

  logic [PHASE_W-1:0] phase_q;
  logic [PHASE_W-1:0] phase_nxt;
  logic               wrap_nxt;
  logic               load;
  depth_e             depth_q;
  depth_e             depth_nxt;
  logic               ss_oe_q;
  logic               ref_oe_q;

  assign load = wrap_nxt || !pd_n;

  sscg_phase_ctr #(.PHASE_W(PHASE_W)) u_ctr (
    .clk       (clk),
    .rst       (rst),
    .run       (pd_n),
    .phase_q   (phase_q),
    .phase_nxt (phase_nxt),
    .wrap_nxt  (wrap_nxt)
  );

  sscg_depth_sel u_dsel (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .sel       (sel),
    .depth_q   (depth_q),
    .depth_nxt (depth_nxt)
  );

  sscg_tri_shaper #(
    .PHASE_W  (PHASE_W),
    .OFS_W    (OFS_W),
    .PEAK_LO  (PEAK_LO),
    .PEAK_HI  (PEAK_HI),
    .PEAK_MID (PEAK_MID)
  ) u_shape (
    .clk       (clk),
    .rst       (rst),
    .phase_nxt (phase_nxt),
    .depth_nxt (depth_nxt),
    .offset_q  (offset)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ss_oe_q  <= 1'b0;
      ref_oe_q <= 1'b0;
    end else begin
      ss_oe_q  <= pd_n;
      ref_oe_q <= pd_n;
    end
  end

  assign ss_oe  = ss_oe_q;
  assign ref_oe = ref_oe_q;

  logic signed [OFS_W-1:0] peak_chk;
  always_comb begin
    case (depth_q)
      DEPTH_LO: peak_chk = OFS_W'(PEAK_LO);
      DEPTH_HI: peak_chk = OFS_W'(PEAK_HI);
      default:  peak_chk = OFS_W'(PEAK_MID);
    endcase
  end

  // R4: bottom of the triangle hits the full selected depth
  p_peak_r4: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_HALF) |-> (offset == -peak_chk));

  // R4: period start sits at nominal
  p_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (phase_q == '0) |-> (offset == '0));

  // R7: power-down quiets the profile and drops both enables
  p_pd_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !pd_n |=> (offset == '0 && !ss_oe && !ref_oe));

endmodule

// File: tb/sim_sscg_profile.sv
`timescale 1ns/1ps
module sim_sscg_profile;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               pd_n = 1'b1;
  logic [1:0]         sel = 2'b01;
  logic signed [15:0] offset;
  logic               ss_oe;
  logic               ref_oe;

  int errors = 0;
  int checks = 0;
  int exp_phase = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sscg_profile u0 (
    .clk    (clk),
    .rst    (rst),
    .pd_n   (pd_n),
    .sel    (sel),
    .offset (offset),
    .ss_oe  (ss_oe),
    .ref_oe (ref_oe)
  );

  // {sel, phase, expected offset}
  localparam int NV = 13;
  localparam logic [25:0] VEC [NV] = '{
    {2'b00, 8'd1,   -16'sd1},
    {2'b00, 8'd64,  -16'sd85},
    {2'b00, 8'd128, -16'sd170},
    {2'b00, 8'd192, -16'sd85},
    {2'b00, 8'd255, -16'sd1},
    {2'b01, 8'd64,  -16'sd115},
    {2'b01, 8'd100, -16'sd179},
    {2'b01, 8'd128, -16'sd230},
    {2'b01, 8'd200, -16'sd100},
    {2'b10, 8'd64,  -16'sd25},
    {2'b10, 8'd128, -16'sd50},
    {2'b11, 8'd128, -16'sd50},
    {2'b11, 8'd1,   16'sd0}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    if (rst || !pd_n) exp_phase = 0;
    else              exp_phase = (exp_phase + 1) % 256;
    @(negedge clk);
  endtask

  task automatic to_start();
    do step(); while (exp_phase != 0);
  endtask

  task automatic step_to(input int p);
    while (exp_phase != p) step();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int lo_viol;
    int mn;
    @(negedge clk);
    step();
    step();
    // R1: reset state
    check("R1 offset in reset", offset, 0);
    check("R1 ss_oe in reset", ss_oe, 0);
    check("R1 ref_oe in reset", ref_oe, 0);
    rst = 1'b0;
    step();
    check("R9 ref_oe after reset", ref_oe, 1);
    // R1: first triangle uses mid depth even though sel=01
    step_to(128);
    check("R1 default mid peak", offset, -50);

    // R3 R5 R2: table walk
    for (int i = 0; i < NV; i++) begin
      sel = VEC[i][25:24];
      to_start();
      step_to(int'(VEC[i][23:16]));
      check("R3/R5 table offset", offset, int'($signed(VEC[i][15:0])));
      check("R9 ref_oe ignores sel", ref_oe, 1);
    end

    // R6: change mid-ramp is deferred
    sel = 2'b00;
    to_start();
    step_to(64);
    sel = 2'b01;
    step_to(100);
    check("R6 old depth kept mid-ramp", offset, -132);
    to_start();
    step_to(100);
    check("R6 new depth after wrap", offset, -179);

    // R4 R2: full sweep at low depth
    sel = 2'b00;
    to_start();
    to_start();
    check("R4 zero at period start", offset, 0);
    lo_viol = 0;
    mn = 0;
    for (int k = 0; k < 256; k++) begin
      step();
      if (offset > 0) lo_viol++;
      if (offset < mn) mn = offset;
      if (exp_phase == 128) check("R4 peak at half period", offset, -170);
    end
    check("R4 never above nominal", lo_viol, 0);
    check("R4 sweep minimum", mn, -170);

    // R7: power-down from mid ramp
    step_to(50);
    pd_n = 1'b0;
    step();
    check("R7 ss_oe low", ss_oe, 0);
    check("R7 ref_oe low", ref_oe, 0);
    check("R7 offset nominal", offset, 0);
    sel = 2'b01;
    for (int k = 0; k < 5; k++) step();
    check("R7 offset held", offset, 0);
    check("R9 ref_oe matches ss_oe", ref_oe, ss_oe);

    // R8: restart from zero with depth taken in power-down
    pd_n = 1'b1;
    step();
    check("R8 restart phase 1", offset, -1);
    check("R8 ss_oe back", ss_oe, 1);
    step_to(128);
    check("R8 depth from pd sel", offset, -230);

    // R1: reset while running
    step_to(40);
    rst = 1'b1;
    step();
    check("R1 offset after mid-run reset", offset, 0);
    rst = 1'b0;
    step_to(128);
    check("R1 mid peak after mid-run reset", offset, -50);

    finish_run();
  end

endmodule